// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block forms a 64-bit packed result from two 64-bit packed operands, called vs and vt, by moving whole lanes into a fixed arrangement. A 5-bit shuffle-op field selects the lane size (bytes or halfwords) and which arrangement to apply. The available arrangements interleave the upper or lower halves of the two operands, gather their odd or even lanes, widen the low bytes of vs into halfwords by pairing each byte with a byte of sign copies, swap adjacent halfwords between operands, and repeat the upper or lower halfword pairs of each operand.

The unit is purely combinational. It sits in a media datapath between operand fetch and write-back. Every encoding that has no arrangement raises an illegal flag and forces the result to zero, so the caller can trap or discard it.

Top module: `shuffle_unit`

## Requirements
- R1: Lane 0 is bits [7:0] in byte mode and bits [15:0] in halfword mode. When shop[1:0] = 01 the unit works on halfwords and the pattern index is shop[4:2]. When shop[0] = 0 it works on bytes and the index is shop[4:1]. When shop[1:0] = 11 the encoding is illegal.
- R2: Byte index 1 and byte index 6 both interleave the upper halves. Result lanes 0..7 are vt4, vs4, vt5, vs5, vt6, vs6, vt7, vs7.
- R3: Byte index 2 and byte index 7 both interleave the lower halves. Result lanes 0..7 are vt0, vs0, vt1, vs1, vt2, vs2, vt3, vs3.
- R4: Byte index 4 gathers odd lanes, giving vt1, vt3, vt5, vt7, vs1, vs3, vs5, vs7. Byte index 5 gathers even lanes, giving vt0, vt2, vt4, vt6, vs0, vs2, vs4, vs6.
- R5: Byte index 3 gives vs0, F0, vs1, F1, vs2, F2, vs3, F3. Each Fi is 0xFF when bit 7 of vs lane i is 1 and 0x00 when it is 0.
- R6: Halfword index 0 gives vt2, vs2, vt3, vs3. Halfword index 1 gives vt0, vs0, vt1, vs1.
- R7: Halfword index 2 gives vt1, vt3, vs1, vs3. Halfword index 4 gives vt1, vs0, vt3, vs2.
- R8: Halfword index 6 gives vt2, vt3, vs2, vs3. Halfword index 7 gives vt0, vt1, vs0, vs1.
- R9: The following encodings assert illegal_o and drive result_o to zero: byte index 0, byte indices 8 to 15, halfword indices 3 and 5, and shop[1:0] = 11. Every other encoding drives illegal_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vs_i | input | 64 | First packed operand |
| vt_i | input | 64 | Second packed operand |
| shop_i | input | 5 | Shuffle-op field: lane size and pattern index |
| result_o | output | 64 | Rearranged packed result |
| illegal_o | output | 1 | High for an encoding with no pattern |

## Verification
The case hardest to reach from the ports is a byte index above 7. It needs shop bit 4 set while bit 0 is clear, and that region looks like valid byte space, so a stimulus that only walks the listed patterns never touches it. The bench drives those encodings on purpose, together with operands that are far from zero, so that a missing zero forcing would show up in the result.

The sign-fill pattern is the other risk. Its operands place alternating lane MSBs in the four low vs lanes, and one operand gives all four lanes the same MSB, so each fill byte must follow its own source lane. The legacy aliases are applied with the same operands as their primary encodings, so the two results must match.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int SHOP_W = 5;

  typedef enum logic [3:0] {
    PAT_NONE,
    PAT_MIXH,
    PAT_MIXL,
    PAT_PACH,
    PAT_PACL,
    PAT_UNPK,
    PAT_BFLY,
    PAT_REPA,
    PAT_REPB
  } pat_e;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_VS,
    SRC_VT,
    SRC_SIGN
  } src_e;
endpackage

// File: rtl/shuf_decode.sv
module shuf_decode
  import shuf_pkg::*;
(
  input  logic [SHOP_W-1:0] op_i,
  output logic              half_o,
  output pat_e              pat_o,
  output logic              illegal_o
);
  logic [2:0] hidx;
  logic [3:0] bidx;

  assign hidx = op_i[4:2];
  assign bidx = op_i[4:1];

  always_comb begin
    half_o = 1'b0;
    pat_o  = PAT_NONE;
    if (op_i[1:0] == 2'b01) begin
      half_o = 1'b1;
      case (int'(hidx))
        0:       pat_o = PAT_MIXH;
        1:       pat_o = PAT_MIXL;
        2:       pat_o = PAT_PACH;
        4:       pat_o = PAT_BFLY;
        6:       pat_o = PAT_REPA;
        7:       pat_o = PAT_REPB;
        default: pat_o = PAT_NONE;
      endcase
    end else if (!op_i[0]) begin
      case (int'(bidx))
        1, 6:    pat_o = PAT_MIXH;
        2, 7:    pat_o = PAT_MIXL;
        3:       pat_o = PAT_UNPK;
        4:       pat_o = PAT_PACH;
        5:       pat_o = PAT_PACL;
        default: pat_o = PAT_NONE;
      endcase
    end
  end

  assign illegal_o = (pat_o == PAT_NONE);
endmodule

// File: rtl/shuf_route.sv
module shuf_route
  import shuf_pkg::*;
#(
  parameter int NB = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          half_i,
  input  pat_e          pat_i,
  output src_e          src_o [NB],
  output logic [IW-1:0] idx_o [NB]
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      int n;
      int k;
      int e;
      int bi;
      src_e es;
      n  = half_i ? NB / 2 : NB;
      k  = half_i ? b / 2 : b;
      es = SRC_ZERO;
      e  = 0;
      case (pat_i)
        PAT_MIXH: begin
          es = (k % 2 == 0) ? SRC_VT : SRC_VS;
          e  = n / 2 + k / 2;
        end
        PAT_MIXL: begin
          es = (k % 2 == 0) ? SRC_VT : SRC_VS;
          e  = k / 2;
        end
        PAT_PACH: begin
          es = (k < n / 2) ? SRC_VT : SRC_VS;
          e  = 2 * (k % (n / 2)) + 1;
        end
        PAT_PACL: begin
          es = (k < n / 2) ? SRC_VT : SRC_VS;
          e  = 2 * (k % (n / 2));
        end
        PAT_UNPK: begin
          es = (k % 2 == 0) ? SRC_VS : SRC_SIGN;
          e  = k / 2;
        end
        PAT_BFLY: begin
          es = (k % 2 == 0) ? SRC_VT : SRC_VS;
          e  = (k % 2 == 0) ? k + 1 : k - 1;
        end
        PAT_REPA: begin
          es = (k < n / 2) ? SRC_VT : SRC_VS;
          e  = (k < n / 2) ? n / 2 + k : k;
        end
        PAT_REPB: begin
          es = (k < n / 2) ? SRC_VT : SRC_VS;
          e  = (k < n / 2) ? k : k - n / 2;
        end
        default: begin
          es = SRC_ZERO;
          e  = 0;
        end
      endcase
      bi = half_i ? 2 * e + (b % 2) : e;
      src_o[b] = es;
      idx_o[b] = bi[IW-1:0];
    end
  end
endmodule

// File: rtl/shuf_xbar.sv
module shuf_xbar
  import shuf_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 8,
  localparam int DW = NB * BW,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [DW-1:0] vs_i,
  input  logic [DW-1:0] vt_i,
  input  src_e          src_i [NB],
  input  logic [IW-1:0] idx_i [NB],
  output logic [DW-1:0] res_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_d;
    always_comb begin
      case (src_i[b])
        SRC_VS:   lane_d = vs_i[int'(idx_i[b]) * BW +: BW];
        SRC_VT:   lane_d = vt_i[int'(idx_i[b]) * BW +: BW];
        SRC_SIGN: lane_d = {BW{vs_i[int'(idx_i[b]) * BW + BW - 1]}};
        default:  lane_d = '0;
      endcase
    end
    assign res_o[b*BW +: BW] = lane_d;
  end
endmodule

// File: rtl/shuffle_unit.sv
module shuffle_unit
  import shuf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB = DATA_W / BYTE_W,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [DATA_W-1:0] vs_i,
  input  logic [DATA_W-1:0] vt_i,
  input  logic [SHOP_W-1:0] shop_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  logic          half_w;
  pat_e          pat_w;
  src_e          src_w [NB];
  logic [IW-1:0] idx_w [NB];

  shuf_decode u_dec (
    .op_i      (shop_i),
    .half_o    (half_w),
    .pat_o     (pat_w),
    .illegal_o (illegal_o)
  );

  shuf_route #(.NB(NB)) u_route (
    .half_i (half_w),
    .pat_i  (pat_w),
    .src_o  (src_w),
    .idx_o  (idx_w)
  );

  shuf_xbar #(.NB(NB), .BW(BYTE_W)) u_xbar (
    .vs_i  (vs_i),
    .vt_i  (vt_i),
    .src_i (src_w),
    .idx_i (idx_w),
    .res_o (result_o)
  );

  always_comb begin
    // R9
    illegal_zero_chk: assert (!illegal_o || result_o == '0);
    // R1
    if (shop_i[1:0] == 2'b11) begin
      bad_format_chk: assert (illegal_o);
    end
    // R5
    if (shop_i == 5'b00110) begin
      for (int i = 0; i < NB / 2; i++) begin
        sign_fill_chk: assert (result_o[(2*i+1)*BYTE_W +: BYTE_W] ==
                               {BYTE_W{vs_i[i*BYTE_W + BYTE_W - 1]}});
      end
    end
    // R2
    if (shop_i == 5'b00010 || shop_i == 5'b01100) begin
      mix_high_first_chk: assert (result_o[BYTE_W-1:0] ==
                                  vt_i[(NB/2)*BYTE_W +: BYTE_W]);
    end
    // R8
    if (shop_i == 5'b11101) begin
      rep_low_chk: assert (result_o[DATA_W/2-1:0] == vt_i[DATA_W/2-1:0]);
    end
  end
endmodule

// File: tb/sim_shuffle_unit.sv
module sim_shuffle_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 20000;

  logic        clk;
  logic [63:0] vs, vt, res;
  logic [4:0]  shop;
  logic        ill;
  int          n_chk = 0;
  int          n_fail = 0;

  shuffle_unit u0 (
    .vs_i      (vs),
    .vt_i      (vt),
    .shop_i    (shop),
    .result_o  (res),
    .illegal_o (ill)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bl(input logic [63:0] v, input int i);
    return v[i*8 +: 8];
  endfunction
  function automatic logic [15:0] hl(input logic [63:0] v, input int i);
    return v[i*16 +: 16];
  endfunction
  function automatic logic [7:0] sf(input logic [63:0] v, input int i);
    return {8{v[i*8+7]}};
  endfunction

  // Expected {illegal, result} built from the requirement lane lists
  function automatic logic [64:0] model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] t);
    logic [63:0] r;
    logic bad;
    r = '0;
    bad = 1'b0;
    if (op[1:0] == 2'b01) begin
      case (op[4:2])
        3'd0: r = {hl(a,3), hl(t,3), hl(a,2), hl(t,2)};
        3'd1: r = {hl(a,1), hl(t,1), hl(a,0), hl(t,0)};
        3'd2: r = {hl(a,3), hl(a,1), hl(t,3), hl(t,1)};
        3'd4: r = {hl(a,2), hl(t,3), hl(a,0), hl(t,1)};
        3'd6: r = {hl(a,3), hl(a,2), hl(t,3), hl(t,2)};
        3'd7: r = {hl(a,1), hl(a,0), hl(t,1), hl(t,0)};
        default: bad = 1'b1;
      endcase
    end else if (!op[0]) begin
      case (op[4:1])
        4'd1, 4'd6: r = {bl(a,7), bl(t,7), bl(a,6), bl(t,6), bl(a,5), bl(t,5), bl(a,4), bl(t,4)};
        4'd2, 4'd7: r = {bl(a,3), bl(t,3), bl(a,2), bl(t,2), bl(a,1), bl(t,1), bl(a,0), bl(t,0)};
        4'd3: r = {sf(a,3), bl(a,3), sf(a,2), bl(a,2), sf(a,1), bl(a,1), sf(a,0), bl(a,0)};
        4'd4: r = {bl(a,7), bl(a,5), bl(a,3), bl(a,1), bl(t,7), bl(t,5), bl(t,3), bl(t,1)};
        4'd5: r = {bl(a,6), bl(a,4), bl(a,2), bl(a,0), bl(t,6), bl(t,4), bl(t,2), bl(t,0)};
        default: bad = 1'b1;
      endcase
    end else begin
      bad = 1'b1;
    end
    return {bad, r};
  endfunction

  task automatic chk(input string req, input logic [4:0] op,
                     input logic [63:0] a, input logic [63:0] t);
    logic [64:0] exp;
    vs = a;
    vt = t;
    shop = op;
    @(posedge clk);
    @(negedge clk);
    exp = model(op, a, t);
    n_chk++;
    if ({ill, res} !== exp) begin
      n_fail++;
      $display("FAIL %s shop=%b actual ill=%b res=%h expected ill=%b res=%h",
               req, op, ill, res, exp[64], exp[63:0]);
    end
  endtask

  localparam logic [63:0] PA = 64'hF7E6_D5C4_B3A2_9180;
  localparam logic [63:0] PB = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PC = 64'h7F80_01FE_807F_FF00;

  task automatic test_quiet;
    chk("R3 zero operands", 5'b00100, '0, '0);
  endtask

  task automatic test_format_and_reserved;
    chk("R1 format 11", 5'b00011, PA, PB);
    chk("R1 format 11 high", 5'b11111, PB, PA);
    chk("R9 byte index 0", 5'b00000, PA, PB);
    for (int i = 8; i < 16; i++) chk("R9 byte index above 7", 5'(i*2), PA, PB);
    chk("R9 half index 3", 5'b01101, PA, PB);
    chk("R9 half index 5", 5'b10101, PA, PB);
  endtask

  task automatic test_byte_mix;
    chk("R2 mix high", 5'b00010, PA, PB);
    chk("R2 mix high alias", 5'b01100, PA, PB);
    chk("R2 mix high swapped", 5'b00010, PB, PC);
    chk("R3 mix low", 5'b00100, PA, PB);
    chk("R3 mix low alias", 5'b01110, PA, PB);
    chk("R3 mix low swapped", 5'b01110, PC, PA);
  endtask

  task automatic test_byte_pack;
    chk("R4 pack odd", 5'b01000, PA, PB);
    chk("R4 pack even", 5'b01010, PA, PB);
    chk("R4 pack odd other", 5'b01000, PC, PA);
  endtask

  task automatic test_byte_sign;
    chk("R5 sign fill mixed", 5'b00110, PA, PB);
    chk("R5 sign fill alt", 5'b00110, PC, PA);
    chk("R5 sign fill all set", 5'b00110, 64'h0000_0000_8090_A0B0, PB);
    chk("R5 sign fill none set", 5'b00110, 64'hFFFF_FFFF_7F10_2030, PB);
  endtask

  task automatic test_half_mix;
    chk("R6 half mix high", 5'b00001, PA, PB);
    chk("R6 half mix low", 5'b00101, PA, PB);
    chk("R6 half mix low other", 5'b00101, PC, PB);
  endtask

  task automatic test_half_pack_bfly;
    chk("R7 half pack odd", 5'b01001, PA, PB);
    chk("R7 half butterfly", 5'b10001, PA, PB);
    chk("R7 half butterfly other", 5'b10001, PB, PC);
  endtask

  task automatic test_half_rep;
    chk("R8 half repeat upper", 5'b11001, PA, PB);
    chk("R8 half repeat lower", 5'b11101, PA, PB);
    chk("R8 half repeat lower other", 5'b11101, PC, PA);
  endtask

  initial begin
    vs = '0;
    vt = '0;
    shop = '0;
    @(negedge clk);
    test_quiet();
    test_format_and_reserved();
    test_byte_mix();
    test_byte_pack();
    test_byte_sign();
    test_half_mix();
    test_half_pack_bfly();
    test_half_rep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule